// File: doc/BRIEF.md
# Dual-Band Numerically Controlled Oscillator

This block is a phase-accumulating oscillator for a transmitter that covers two bands. It runs from a 200 MHz sample clock and keeps a 32-bit phase word. A three-bit channel number selects one of eight preset frequency words. The four low channels set a carrier in the 80 m band, and that carrier is made directly with no mixing. The four high channels set an intermediate frequency between 14 and 18 MHz. That intermediate frequency is later mixed with a 130 MHz local oscillator to reach a carrier in the 2 m band.

A second accumulator runs alongside the main one and makes that 130 MHz local oscillator from a fixed frequency word. A signed deviation input is added to the selected frequency word on every cycle, which gives frequency modulation. The channel can be changed while the block is running. A channel change never clears the phase, so the output stays phase-continuous. The block drives out both full phase words, the most significant phase bit of each as a square wave, and a flag that says whether the current channel needs the mixer.

Top module: `dual_band_nco`

## Requirements
- R1: While `rst` is high, the design clears `phaseWord`, `loPhase`, `vhfPath`, `sqOut` and `loSq` to zero at each clock edge. At the first edge after reset is released, both phase words stay at zero.
- R2: Channels 0 to 3 (`chanSel[2]` = 0) use these frequency words: channel 0 uses 76879915, channel 1 uses 81604379, channel 2 uses 76020921 and channel 3 uses 75806173.
- R3: Channels 4 to 7 (`chanSel[2]` = 1) use these frequency words: channel 4 uses 309022897, channel 5 uses 334255830, channel 6 uses 355730666 and channel 7 uses 377205503.
- R4: The design samples `chanSel` and `fmDev` at clock edge k. From edge k+1 onward, `phaseWord` advances by the word built from them. At edge k itself, the step still uses the word sampled one edge earlier.
- R5: A change of channel never resets or reloads `phaseWord`. The next phase is always the previous phase plus a frequency word.
- R6: `fmDev` is a 16-bit two's-complement value. The design sign-extends it to 32 bits and adds it to the selected channel word.
- R7: From the second edge after reset, `loPhase` advances by exactly 2791728742 on every edge, whatever the values of `chanSel` and `fmDev`.
- R8: `sqOut` equals bit 31 of `phaseWord`, and `loSq` equals bit 31 of `loPhase`.
- R9: At each edge out of reset, `vhfPath` takes the value of `chanSel[2]`. Its timing matches the timing of the frequency word.
- R10: Phase arithmetic wraps modulo 2^32, so the phase word steps down whenever the sum overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz sample clock |
| rst | input | 1 | Synchronous reset, active high |
| chanSel | input | 3 | Channel number. Bit 2 selects the mixed path |
| fmDev | input | 16 | Signed frequency deviation added to the channel word |
| phaseWord | output | 32 | Main accumulator phase |
| sqOut | output | 1 | Square wave from the main phase |
| loPhase | output | 32 | Local oscillator accumulator phase |
| loSq | output | 1 | Square wave from the local oscillator phase |
| vhfPath | output | 1 | High when the current word is an intermediate frequency |

## Verification
A wrong frequency word latched into the block shows up one edge later as a wrong step in `phaseWord`. That error then persists, because an accumulator never forgets an offset. A phase clear on a channel change, or a dropped sign bit in the deviation, shows up at the first compared cycle after the stimulus. For these reasons, both phase words and `vhfPath` are compared against a behavioural model at every clock, and the explicit checks look at step sizes right across channel switches.

// File: rtl/dual_band_nco_pkg.sv
package dual_band_nco_pkg;

  localparam int PHASE_W  = 32;
  localparam int CHAN_W   = 3;
  localparam int NUM_CHAN = 1 << CHAN_W;
  localparam int NUM_ACC  = 2;

  // 130 MHz at a 200 MHz clock: round(0.65 * 2^32)
  localparam logic [PHASE_W-1:0] LO_INC = 32'd2791728742;

  typedef struct packed {
    logic               advance;
    logic               vhfPath;
    logic [PHASE_W-1:0] incWord;
  } ncoStrobe_t;

  // Preset frequency words: the low half is the direct HF band, the high half the IF band
  function automatic logic [PHASE_W-1:0] baseInc(input logic [CHAN_W-1:0] sel);
    logic [PHASE_W-1:0] w;
    case (sel)
      3'd0:    w = 32'd76879915;
      3'd1:    w = 32'd81604379;
      3'd2:    w = 32'd76020921;
      3'd3:    w = 32'd75806173;
      3'd4:    w = 32'd309022897;
      3'd5:    w = 32'd334255830;
      3'd6:    w = 32'd355730666;
      default: w = 32'd377205503;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/dual_band_nco_ctrl.sv
module dual_band_nco_ctrl
  import dual_band_nco_pkg::*;
#(
  parameter int DEV_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CHAN_W-1:0]       chanSel,
  input  logic signed [DEV_W-1:0] fmDev,
  output ncoStrobe_t              strb
);

  localparam int EXT_W = PHASE_W - DEV_W;

  logic [PHASE_W-1:0] devExt;
  logic [PHASE_W-1:0] nextInc;

  always_comb begin
    devExt  = {{EXT_W{fmDev[DEV_W-1]}}, fmDev};
    nextInc = baseInc(chanSel) + devExt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb.advance <= 1'b0;
      strb.vhfPath <= 1'b0;
      strb.incWord <= '0;
    end else begin
      strb.advance <= 1'b1;
      strb.vhfPath <= chanSel[CHAN_W-1];
      strb.incWord <= nextInc;
    end
  end

endmodule

// File: rtl/dual_band_nco_acc.sv
module dual_band_nco_acc
  import dual_band_nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic [PHASE_W-1:0] stepWord,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (advance) phase <= phase + stepWord;
  end

endmodule

// File: rtl/dual_band_nco_dp.sv
module dual_band_nco_dp
  import dual_band_nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ncoStrobe_t         strb,
  output logic [PHASE_W-1:0] mainPhase,
  output logic [PHASE_W-1:0] loPhase
);

  logic [PHASE_W-1:0] accPhase [NUM_ACC];

  // Index 0 follows the selected channel word, index 1 is the fixed local oscillator
  for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
    logic [PHASE_W-1:0] stepSel;
    if (gi == 0) begin : g_main
      assign stepSel = strb.incWord;
    end else begin : g_lo
      assign stepSel = LO_INC;
    end
    dual_band_nco_acc u_acc (
      .clk      (clk),
      .rst      (rst),
      .advance  (strb.advance),
      .stepWord (stepSel),
      .phase    (accPhase[gi])
    );
  end

  assign mainPhase = accPhase[0];
  assign loPhase   = accPhase[1];

endmodule

// File: rtl/dual_band_nco.sv
module dual_band_nco
  import dual_band_nco_pkg::*;
#(
  parameter int DEV_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CHAN_W-1:0]       chanSel,
  input  logic signed [DEV_W-1:0] fmDev,
  output logic [PHASE_W-1:0]      phaseWord,
  output logic                    sqOut,
  output logic [PHASE_W-1:0]      loPhase,
  output logic                    loSq,
  output logic                    vhfPath
);

  ncoStrobe_t strb;

  dual_band_nco_ctrl #(.DEV_W(DEV_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .chanSel (chanSel),
    .fmDev   (fmDev),
    .strb    (strb)
  );

  dual_band_nco_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .mainPhase (phaseWord),
    .loPhase   (loPhase)
  );

  assign sqOut   = phaseWord[PHASE_W-1];
  assign loSq    = loPhase[PHASE_W-1];
  assign vhfPath = strb.vhfPath;

endmodule

// File: rtl/dual_band_nco_chk.sv
module dual_band_nco_chk
  import dual_band_nco_pkg::*;
#(
  parameter int DEV_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [CHAN_W-1:0]       chanSel,
  input logic signed [DEV_W-1:0] fmDev,
  input logic [PHASE_W-1:0]      phaseWord,
  input logic [PHASE_W-1:0]      loPhase,
  input logic                    vhfPath
);

  function automatic logic [PHASE_W-1:0] expStep(input logic [CHAN_W-1:0] c,
                                                 input logic [DEV_W-1:0] d);
    return baseInc(c) + {{(PHASE_W-DEV_W){d[DEV_W-1]}}, d};
  endfunction

  // R1: state seen after a reset edge is all zero
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (phaseWord == '0 && loPhase == '0 && !vhfPath));

  // R4 (with R2, R3, R6, R10): step equals the word sampled two edges back
  p_step_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |->
      ((phaseWord - $past(phaseWord)) == expStep($past(chanSel, 2), $past(fmDev, 2))));

  // R7: fixed local oscillator step
  p_lo_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> ((loPhase - $past(loPhase)) == LO_INC));

  // R9: path flag follows the channel's top bit one edge later
  p_path_flag_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vhfPath == $past(chanSel[CHAN_W-1])));

endmodule

bind dual_band_nco dual_band_nco_chk #(.DEV_W(DEV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chanSel   (chanSel),
  .fmDev     (fmDev),
  .phaseWord (phaseWord),
  .loPhase   (loPhase),
  .vhfPath   (vhfPath)
);

// File: tb/dual_band_nco_test.sv
module dual_band_nco_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [2:0]  chanSel = '0;
  logic [15:0] fmDev = '0;
  logic [31:0] phaseWord, loPhase;
  logic        sqOut, loSq, vhfPath;

  dual_band_nco uut (
    .clk(clk), .rst(rst), .chanSel(chanSel), .fmDev(fmDev),
    .phaseWord(phaseWord), .sqOut(sqOut), .loPhase(loPhase),
    .loSq(loSq), .vhfPath(vhfPath)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] LO_STEP = 32'd2791728742;
  logic [31:0] chanWord [8];
  initial begin
    chanWord[0] = 32'd76879915;  chanWord[1] = 32'd81604379;
    chanWord[2] = 32'd76020921;  chanWord[3] = 32'd75806173;
    chanWord[4] = 32'd309022897; chanWord[5] = 32'd334255830;
    chanWord[6] = 32'd355730666; chanWord[7] = 32'd377205503;
  end

  // behavioural reference
  logic [31:0] mPhase = '0, mLo = '0;
  logic [31:0] pendWord [$];
  logic        mRunning = 1'b0;
  logic        mVhf = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [2:0] c,
                      input logic [15:0] d, input string tag);
    rst = r; chanSel = c; fmDev = d;
    @(posedge clk);
    if (r) begin
      mPhase = '0; mLo = '0; mRunning = 1'b0; mVhf = 1'b0;
      pendWord.delete();
    end else begin
      if (mRunning) begin
        mPhase = mPhase + pendWord.pop_front();
        mLo    = mLo + LO_STEP;
      end
      pendWord.push_back(chanWord[c] + {{16{d[15]}}, d});
      mRunning = 1'b1;
      mVhf = c[2];
    end
    @(negedge clk);
    chk(tag,  "phaseWord", phaseWord, mPhase);
    chk("R7", "loPhase", loPhase, mLo);
    chk("R8", "sqOut", {31'b0, sqOut}, {31'b0, mPhase[31]});
    chk("R8", "loSq", {31'b0, loSq}, {31'b0, mLo[31]});
    chk("R9", "vhfPath", {31'b0, vhfPath}, {31'b0, mVhf});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    int wraps;
    repeat (3) step(1'b1, 3'd5, 16'h1234, "R1");
    chk("R1", "reset phase", phaseWord, 32'd0);
    chk("R1", "reset lo", loPhase, 32'd0);
    step(1'b0, 3'd0, 16'd0, "R1");
    chk("R1", "first edge phase", phaseWord, 32'd0);
    chk("R1", "first edge lo", loPhase, 32'd0);

    // R2: direct band words
    for (int c = 0; c < 4; c++) begin
      step(1'b0, 3'(c), 16'd0, "R2");
      prev = phaseWord;
      step(1'b0, 3'(c), 16'd0, "R2");
      chk("R2", "HF step", phaseWord - prev, chanWord[c]);
    end

    // R4: switch to channel 6, first step still uses channel 3
    prev = phaseWord;
    step(1'b0, 3'd6, 16'd0, "R4");
    chk("R4", "old word after switch", phaseWord - prev, chanWord[3]);
    prev = phaseWord;
    step(1'b0, 3'd6, 16'd0, "R4");
    chk("R4", "new word one edge later", phaseWord - prev, chanWord[6]);

    // R3: IF band words
    for (int c = 4; c < 8; c++) begin
      step(1'b0, 3'(c), 16'd0, "R3");
      prev = phaseWord;
      step(1'b0, 3'(c), 16'd0, "R3");
      chk("R3", "IF step", phaseWord - prev, chanWord[c]);
    end

    // R5: continuity across a band change
    prev = phaseWord;
    step(1'b0, 3'd1, 16'd0, "R5");
    chk("R5", "no clear on change", phaseWord, prev + chanWord[7]);

    // R6: signed deviation
    step(1'b0, 3'd2, 16'hFC18, "R6");
    prev = phaseWord;
    step(1'b0, 3'd2, 16'h7FFF, "R6");
    chk("R6", "dev -1000", phaseWord - prev, chanWord[2] - 32'd1000);
    prev = phaseWord;
    step(1'b0, 3'd4, 16'h8000, "R6");
    chk("R6", "dev +32767", phaseWord - prev, chanWord[2] + 32'd32767);
    prev = phaseWord;
    step(1'b0, 3'd4, 16'd0, "R6");
    chk("R6", "dev -32768", phaseWord - prev, chanWord[4] - 32'd32768);

    // R10: wrap on the highest IF word
    wraps = 0;
    for (int i = 0; i < 40; i++) begin
      prev = phaseWord;
      step(1'b0, 3'd7, 16'd0, "R10");
      if (phaseWord < prev) wraps++;
    end
    chk("R10", "wrap count nonzero", {31'b0, wraps > 0}, 32'd1);

    // mixed random stimulus
    for (int i = 0; i < 3000; i++)
      step(1'b0, 3'($urandom_range(7)), 16'($urandom), "R6");

    // R1: reset in mid run
    step(1'b1, 3'd3, 16'd77, "R1");
    chk("R1", "mid reset phase", phaseWord, 32'd0);
    step(1'b0, 3'd6, 16'd0, "R1");
    chk("R1", "mid reset hold", phaseWord, 32'd0);
    for (int i = 0; i < 20; i++) step(1'b0, 3'd6, 16'd5, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule